// File: doc/BRIEF.md
# BCD calendar clock with update-inhibit

This block is a register-mapped calendar clock. A chain of packed-BCD counters for seconds, minutes, hours, day of month, day of week, month, two-digit year and century advances once for every pulse on a once-per-second tick input. Software reads and writes byte-wide registers over a small synchronous bus. These registers are a shadow copy of the counters. The whole copy is refreshed in one step after each tick, so a read never mixes fields taken from two different seconds.

A control bit freezes the shadow copy. While the copy is frozen, the counters keep running. Software can read a stable snapshot, or it can write new time and date values into the shadow registers. When the bit is cleared, any written values are loaded into the counters. If nothing was written, the shadow copy is refreshed at once. An inhibit request that arrives while a refresh is pending or running does not take effect until that refresh has completed.

The transfer sequencer has four states. RUN is the normal state. COPY refreshes the shadow from the counters. HOLD keeps the shadow frozen. LOAD commits shadow writes to the counters. The transitions are:
- RUN goes to COPY on a tick, and to HOLD when inhibit is set.
- COPY stays in COPY on a new tick, goes to HOLD when inhibit is set, and otherwise returns to RUN.
- HOLD stays in HOLD while inhibit is set. When inhibit clears, HOLD goes to LOAD if a time register was written, and to COPY if none was.
- LOAD always returns to RUN.

Top module: `rtc_shadow_clock`

## Requirements
- R1: After reset every shadow register reads its reset value: seconds 0x00, minutes 0x00, hours 0x00, day of month 0x01, day of week 0x01, month 0x01, year 0x00, century 0x20. The control register reads 0x00.
- R2: Seconds and minutes count in packed BCD (0x09 is followed by 0x10) and wrap from 0x59 to 0x00, carrying into the next field. Hours wrap from 0x23 to 0x00 and carry into the day.
- R3: The day of month wraps to 0x01 after the last day of the month: 0x30 for April, June, September and November, 0x31 for the other long months. The month wraps from 0x12 to 0x01 and carries into the year.
- R4: February has 29 days when the full year (century times 100 plus year) is divisible by 4, except when the year is 00 and the century is not divisible by 4. Otherwise it has 28 days.
- R5: When the year wraps from 0x99 to 0x00, the century increments.
- R6: The day of week advances on every day change and wraps from 0x07 to 0x01, regardless of the date.
- R7: Control bit 3 is the inhibit bit. While the shadow is frozen, ticks do not change any shadow register.
- R8: The counters keep counting while the shadow is frozen. After inhibit clears with no writes made, the shadow shows the advanced count within a few clock cycles.
- R9: Time registers written while frozen are loaded into the counters when inhibit clears, and counting continues from the written values.
- R10: Writes to time registers while the shadow is not frozen are ignored.
- R11: If inhibit is set in the same cycle as a tick, or during the refresh that follows a tick, the refresh completes before the shadow freezes.
- R12: A read of the control register returns the inhibit bit in bit 3 and a read-only frozen flag in bit 7. All other bits read 0.
- R13: Reads are registered, so data appears the cycle after the read strobe. Unmapped addresses (1, 3, 5, 7, C, D, F) read 0x00. The map is: 0 seconds, 2 minutes, 4 hours, 6 day of month, 8 day of week, 9 month, A year, B century, E control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The tick and the inhibit request can land in the same cycle. When they do, the refresh must win and the freeze must follow it. The bench provokes this by driving a tick and a control write of inhibit on the same edge, and again by writing inhibit one cycle after the tick, while the refresh is running. In both cases it reads the seconds register and expects the new second, not the old one. It also expects the frozen flag set, and the value unchanged by a later tick.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    // one byte per field, packed BCD
    typedef struct packed {
        logic [DATA_W-1:0] cent;
        logic [DATA_W-1:0] year;
        logic [DATA_W-1:0] mon;
        logic [DATA_W-1:0] wday;
        logic [DATA_W-1:0] mday;
        logic [DATA_W-1:0] hour;
        logic [DATA_W-1:0] min;
        logic [DATA_W-1:0] sec;
    } rtc_cal_t;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_COPY = 2'd1,
        ST_HOLD = 2'd2,
        ST_LOAD = 2'd3
    } rtc_xfer_e;

    localparam logic [ADDR_W-1:0] A_SEC  = 4'h0;
    localparam logic [ADDR_W-1:0] A_MIN  = 4'h2;
    localparam logic [ADDR_W-1:0] A_HOUR = 4'h4;
    localparam logic [ADDR_W-1:0] A_MDAY = 4'h6;
    localparam logic [ADDR_W-1:0] A_WDAY = 4'h8;
    localparam logic [ADDR_W-1:0] A_MON  = 4'h9;
    localparam logic [ADDR_W-1:0] A_YEAR = 4'hA;
    localparam logic [ADDR_W-1:0] A_CENT = 4'hB;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'hE;

    localparam int INH_BIT    = 3;
    localparam int FROZEN_BIT = 7;

    localparam rtc_cal_t CAL_RESET = {8'h20, 8'h00, 8'h01, 8'h01,
                                      8'h01, 8'h00, 8'h00, 8'h00};

    // {wrap, next}: wraps to lo once value reaches hi
    function automatic logic [DATA_W:0] bcd_step(input logic [DATA_W-1:0] v,
                                                 input logic [DATA_W-1:0] hi,
                                                 input logic [DATA_W-1:0] lo);
        logic [DATA_W:0] r;
        if (v >= hi)
            r = {1'b1, lo};
        else if (v[3:0] >= 4'd9)
            r = {1'b0, v[7:4] + 4'd1, 4'h0};
        else
            r = {1'b0, v + 8'd1};
        return r;
    endfunction

    // a BCD pair is a multiple of 4 when ones + 2*tens[0] is
    function automatic logic bcd_div4(input logic [DATA_W-1:0] v);
        logic [3:0] s;
        s = v[3:0] + {2'b00, v[4], 1'b0};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic is_leap(input logic [DATA_W-1:0] year,
                                     input logic [DATA_W-1:0] cent);
        return (year == 8'h00) ? bcd_div4(cent) : bcd_div4(year);
    endfunction

    function automatic logic [DATA_W-1:0] month_len(input logic [DATA_W-1:0] mon,
                                                    input logic leap);
        logic [DATA_W-1:0] d;
        unique case (mon)
            8'h02:                      d = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
    import rtc_shadow_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     load,
    input  rtc_cal_t load_val,
    output rtc_cal_t cal
);

    rtc_cal_t        nxt;
    logic [DATA_W:0] s_r, m_r, h_r, d_r, w_r, mo_r, y_r, c_r;
    logic            min_go, hour_go, day_go, mon_go, year_go, cent_go;

    always_comb begin
        s_r  = bcd_step(cal.sec,  8'h59, 8'h00);
        m_r  = bcd_step(cal.min,  8'h59, 8'h00);
        h_r  = bcd_step(cal.hour, 8'h23, 8'h00);
        d_r  = bcd_step(cal.mday, month_len(cal.mon, is_leap(cal.year, cal.cent)), 8'h01);
        w_r  = bcd_step(cal.wday, 8'h07, 8'h01);
        mo_r = bcd_step(cal.mon,  8'h12, 8'h01);
        y_r  = bcd_step(cal.year, 8'h99, 8'h00);
        c_r  = bcd_step(cal.cent, 8'h99, 8'h00);

        min_go  = s_r[DATA_W];
        hour_go = min_go  & m_r[DATA_W];
        day_go  = hour_go & h_r[DATA_W];
        mon_go  = day_go  & d_r[DATA_W];
        year_go = mon_go  & mo_r[DATA_W];
        cent_go = year_go & y_r[DATA_W];

        nxt     = cal;
        nxt.sec = s_r[DATA_W-1:0];
        if (min_go)  nxt.min  = m_r[DATA_W-1:0];
        if (hour_go) nxt.hour = h_r[DATA_W-1:0];
        if (day_go) begin
            nxt.mday = d_r[DATA_W-1:0];
            nxt.wday = w_r[DATA_W-1:0];
        end
        if (mon_go)  nxt.mon  = mo_r[DATA_W-1:0];
        if (year_go) nxt.year = y_r[DATA_W-1:0];
        if (cent_go) nxt.cent = c_r[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cal <= CAL_RESET;
        else if (load)
            cal <= load_val;
        else if (tick)
            cal <= nxt;
    end

endmodule

// File: rtl/rtc_xfer_fsm.sv
module rtc_xfer_fsm
    import rtc_shadow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic inhibit,
    input  logic dirty,
    output logic copy_en,
    output logic load_en,
    output logic frozen
);

    rtc_xfer_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_RUN;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (tick)         state_nxt = ST_COPY;
                else if (inhibit) state_nxt = ST_HOLD;
            end
            ST_COPY: begin
                if (tick)         state_nxt = ST_COPY;
                else if (inhibit) state_nxt = ST_HOLD;
                else              state_nxt = ST_RUN;
            end
            ST_HOLD: begin
                if (!inhibit)     state_nxt = dirty ? ST_LOAD : ST_COPY;
            end
            ST_LOAD: state_nxt = ST_RUN;
            default: state_nxt = ST_RUN;
        endcase
    end

    always_comb begin
        copy_en = 1'b0;
        load_en = 1'b0;
        frozen  = 1'b0;
        unique case (state)
            ST_RUN:  ;
            ST_COPY: copy_en = 1'b1;
            ST_HOLD: frozen  = 1'b1;
            ST_LOAD: load_en = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/rtc_user_regs.sv
module rtc_user_regs
    import rtc_shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  rtc_cal_t          cnt_cal,
    input  logic              copy_en,
    input  logic              load_en,
    input  logic              frozen,
    output rtc_cal_t          user_cal,
    output logic              inhibit,
    output logic              dirty
);

    logic              is_time;
    logic              wr_time;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        unique case (bus_addr)
            A_SEC, A_MIN, A_HOUR, A_MDAY,
            A_WDAY, A_MON, A_YEAR, A_CENT: is_time = 1'b1;
            default:                       is_time = 1'b0;
        endcase
    end

    assign wr_time = bus_wr && frozen && is_time;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            user_cal <= CAL_RESET;
        end else if (copy_en) begin
            user_cal <= cnt_cal;
        end else if (wr_time) begin
            unique case (bus_addr)
                A_SEC:   user_cal.sec  <= bus_wdata;
                A_MIN:   user_cal.min  <= bus_wdata;
                A_HOUR:  user_cal.hour <= bus_wdata;
                A_MDAY:  user_cal.mday <= bus_wdata;
                A_WDAY:  user_cal.wday <= bus_wdata;
                A_MON:   user_cal.mon  <= bus_wdata;
                A_YEAR:  user_cal.year <= bus_wdata;
                A_CENT:  user_cal.cent <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            inhibit <= 1'b0;
        else if (bus_wr && bus_addr == A_CTRL)
            inhibit <= bus_wdata[INH_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            dirty <= 1'b0;
        else if (load_en)
            dirty <= 1'b0;
        else if (wr_time)
            dirty <= 1'b1;
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            A_SEC:  rd_mux = user_cal.sec;
            A_MIN:  rd_mux = user_cal.min;
            A_HOUR: rd_mux = user_cal.hour;
            A_MDAY: rd_mux = user_cal.mday;
            A_WDAY: rd_mux = user_cal.wday;
            A_MON:  rd_mux = user_cal.mon;
            A_YEAR: rd_mux = user_cal.year;
            A_CENT: rd_mux = user_cal.cent;
            A_CTRL: begin
                rd_mux[INH_BIT]    = inhibit;
                rd_mux[FROZEN_BIT] = frozen;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/rtc_shadow_clock.sv
module rtc_shadow_clock
    import rtc_shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    rtc_cal_t cnt_cal;
    rtc_cal_t user_cal;
    logic     copy_en;
    logic     load_en;
    logic     frozen;
    logic     inhibit;
    logic     dirty;

    rtc_cal_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .load     (load_en),
        .load_val (user_cal),
        .cal      (cnt_cal)
    );

    rtc_xfer_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sec_tick),
        .inhibit (inhibit),
        .dirty   (dirty),
        .copy_en (copy_en),
        .load_en (load_en),
        .frozen  (frozen)
    );

    rtc_user_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_cal   (cnt_cal),
        .copy_en   (copy_en),
        .load_en   (load_en),
        .frozen    (frozen),
        .user_cal  (user_cal),
        .inhibit   (inhibit),
        .dirty     (dirty)
    );

endmodule

// File: rtl/rtc_shadow_checker.sv
module rtc_shadow_checker
    import rtc_shadow_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input rtc_cal_t          cnt_cal,
    input rtc_cal_t          user_cal,
    input logic              copy_en,
    input logic              load_en,
    input logic              frozen
);

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !bus_wr) |=> $stable(user_cal)); // R7

    AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load_en) |=> (cnt_cal != $past(cnt_cal))); // R2

    AST_IDLE_COUNTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !load_en) |=> $stable(cnt_cal)); // R8

    AST_COPY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        copy_en |=> (user_cal == $past(cnt_cal))); // R11

    AST_LOAD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cnt_cal == $past(user_cal))); // R9

    AST_RUN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && !copy_en && bus_wr && bus_addr != A_CTRL) |=> $stable(user_cal)); // R10

    AST_COPY_NOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({copy_en, load_en, frozen})); // R11

endmodule

bind rtc_shadow_clock rtc_shadow_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .cnt_cal  (cnt_cal),
    .user_cal (user_cal),
    .copy_en  (copy_en),
    .load_en  (load_en),
    .frozen   (frozen)
);

// File: tb/rtc_shadow_clock_test.sv
module rtc_shadow_clock_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    rtc_shadow_clock uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick_once();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        idle(3);
    endtask

    // order: cent year mon wday mday hour min sec
    task automatic set_cal(input logic [63:0] c);
        bus_write(4'hE, 8'h08);
        idle(3);
        bus_write(4'h0, c[7:0]);
        bus_write(4'h2, c[15:8]);
        bus_write(4'h4, c[23:16]);
        bus_write(4'h6, c[31:24]);
        bus_write(4'h8, c[39:32]);
        bus_write(4'h9, c[47:40]);
        bus_write(4'hA, c[55:48]);
        bus_write(4'hB, c[63:56]);
        bus_write(4'hE, 8'h00);
        idle(4);
    endtask

    task automatic check_cal(input string tag, input logic [63:0] e);
        logic [7:0] v;
        bus_read(4'h0, v); check({tag, " sec"},  v, e[7:0]);
        bus_read(4'h2, v); check({tag, " min"},  v, e[15:8]);
        bus_read(4'h4, v); check({tag, " hour"}, v, e[23:16]);
        bus_read(4'h6, v); check({tag, " mday"}, v, e[31:24]);
        bus_read(4'h8, v); check({tag, " wday"}, v, e[39:32]);
        bus_read(4'h9, v); check({tag, " mon"},  v, e[47:40]);
        bus_read(4'hA, v); check({tag, " year"}, v, e[55:48]);
        bus_read(4'hB, v); check({tag, " cent"}, v, e[63:56]);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check_cal("R1 reset", {8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});
        bus_read(4'hE, v); check("R1 ctrl", v, 8'h00);
    endtask

    task automatic t_time_roll();
        set_cal({8'h20, 8'h24, 8'h05, 8'h03, 8'h14, 8'h12, 8'h34, 8'h09});
        tick_once();
        check_cal("R2 R9 bcd digit", {8'h20, 8'h24, 8'h05, 8'h03, 8'h14, 8'h12, 8'h34, 8'h10});
        set_cal({8'h20, 8'h24, 8'h05, 8'h03, 8'h14, 8'h12, 8'h59, 8'h59});
        tick_once();
        check_cal("R2 hour carry", {8'h20, 8'h24, 8'h05, 8'h03, 8'h14, 8'h13, 8'h00, 8'h00});
        set_cal({8'h20, 8'h24, 8'h05, 8'h03, 8'h14, 8'h23, 8'h59, 8'h59});
        tick_once();
        check_cal("R2 R6 day carry", {8'h20, 8'h24, 8'h05, 8'h04, 8'h15, 8'h00, 8'h00, 8'h00});
    endtask

    task automatic t_month_roll();
        set_cal({8'h20, 8'h24, 8'h04, 8'h02, 8'h30, 8'h23, 8'h59, 8'h59});
        tick_once();
        check_cal("R3 april end", {8'h20, 8'h24, 8'h05, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00});
        set_cal({8'h20, 8'h24, 8'h01, 8'h02, 8'h30, 8'h23, 8'h59, 8'h59});
        tick_once();
        check_cal("R3 january 31", {8'h20, 8'h24, 8'h01, 8'h03, 8'h31, 8'h00, 8'h00, 8'h00});
        set_cal({8'h19, 8'h99, 8'h12, 8'h07, 8'h31, 8'h23, 8'h59, 8'h59});
        tick_once();
        check_cal("R3 R5 R6 century roll", {8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});
    endtask

    task automatic t_leap();
        set_cal({8'h20, 8'h24, 8'h02, 8'h03, 8'h28, 8'h23, 8'h59, 8'h59});
        tick_once();
        check_cal("R4 leap 2024", {8'h20, 8'h24, 8'h02, 8'h04, 8'h29, 8'h00, 8'h00, 8'h00});
        set_cal({8'h20, 8'h23, 8'h02, 8'h03, 8'h28, 8'h23, 8'h59, 8'h59});
        tick_once();
        check_cal("R4 plain 2023", {8'h20, 8'h23, 8'h03, 8'h04, 8'h01, 8'h00, 8'h00, 8'h00});
        set_cal({8'h21, 8'h00, 8'h02, 8'h03, 8'h28, 8'h23, 8'h59, 8'h59});
        tick_once();
        check_cal("R4 plain 2100", {8'h21, 8'h00, 8'h03, 8'h04, 8'h01, 8'h00, 8'h00, 8'h00});
        set_cal({8'h20, 8'h00, 8'h02, 8'h03, 8'h28, 8'h23, 8'h59, 8'h59});
        tick_once();
        check_cal("R4 leap 2000", {8'h20, 8'h00, 8'h02, 8'h04, 8'h29, 8'h00, 8'h00, 8'h00});
        set_cal({8'h20, 8'h12, 8'h02, 8'h03, 8'h29, 8'h23, 8'h59, 8'h59});
        tick_once();
        check_cal("R4 leap 2012 end", {8'h20, 8'h12, 8'h03, 8'h04, 8'h01, 8'h00, 8'h00, 8'h00});
    endtask

    task automatic t_freeze();
        logic [7:0] v;
        set_cal({8'h20, 8'h24, 8'h06, 8'h01, 8'h10, 8'h10, 8'h20, 8'h30});
        bus_write(4'hE, 8'h08);
        idle(3);
        bus_read(4'hE, v); check("R12 ctrl frozen", v, 8'h88);
        tick_once(); tick_once(); tick_once();
        bus_read(4'h0, v); check("R7 frozen sec", v, 8'h30);
        bus_write(4'hE, 8'h00);
        idle(4);
        bus_read(4'h0, v); check("R8 sec after release", v, 8'h33);
        bus_read(4'hE, v); check("R12 ctrl released", v, 8'h00);
    endtask

    task automatic t_ignored_write();
        logic [7:0] v;
        bus_write(4'h0, 8'h45);
        idle(3);
        bus_read(4'h0, v); check("R10 sec unchanged", v, 8'h33);
        bus_write(4'h4, 8'h07);
        tick_once();
        bus_read(4'h4, v); check("R10 hour unchanged", v, 8'h10);
        bus_read(4'h0, v); check("R10 count kept", v, 8'h34);
        bus_write(4'hE, 8'hF7);
        idle(2);
        bus_read(4'hE, v); check("R12 reserved bits", v, 8'h00);
        bus_write(4'hE, 8'hFF);
        idle(3);
        bus_read(4'hE, v); check("R12 reserved bits set", v, 8'h88);
        bus_write(4'hE, 8'h00);
        idle(4);
    endtask

    task automatic t_race_same_cycle();
        logic [7:0] v;
        set_cal({8'h20, 8'h24, 8'h06, 8'h01, 8'h10, 8'h10, 8'h20, 8'h40});
        @(negedge clk);
        sec_tick = 1'b1; bus_addr = 4'hE; bus_wdata = 8'h08; bus_wr = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0; bus_wr = 1'b0;
        idle(3);
        bus_read(4'h0, v); check("R11 same cycle sec", v, 8'h41);
        bus_read(4'hE, v); check("R11 same cycle frozen", v, 8'h88);
        tick_once();
        bus_read(4'h0, v); check("R11 R7 then frozen", v, 8'h41);
        bus_write(4'hE, 8'h00);
        idle(4);
        bus_read(4'h0, v); check("R11 R8 release", v, 8'h42);
    endtask

    task automatic t_race_in_copy();
        logic [7:0] v;
        set_cal({8'h20, 8'h24, 8'h06, 8'h01, 8'h10, 8'h10, 8'h20, 8'h50});
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0; bus_addr = 4'hE; bus_wdata = 8'h08; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        idle(3);
        bus_read(4'h0, v); check("R11 during copy sec", v, 8'h51);
        bus_read(4'hE, v); check("R11 during copy frozen", v, 8'h88);
        bus_write(4'hE, 8'h00);
        idle(4);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        logic [3:0] holes [7] = '{4'h1, 4'h3, 4'h5, 4'h7, 4'hC, 4'hD, 4'hF};
        for (int i = 0; i < 7; i++) begin
            bus_read(holes[i], v);
            check($sformatf("R13 unmapped %0h", holes[i]), v, 8'h00);
        end
        bus_read(4'h0, v);
        check("R13 registered read", v, 8'h51);
        idle(2);
        check("R13 read data held", bus_rdata, 8'h51);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_time_roll();
        t_month_roll();
        t_leap();
        t_freeze();
        t_ignored_write();
        t_race_same_cycle();
        t_race_in_copy();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule